// File: doc/BRIEF.md
# Fine-Grained Thread Select Scheduler

This block sits in the second stage of a six-stage in-order pipeline (fetch, select, decode, execute, memory, write back). Four hardware threads share that one pipeline. Each cycle the block picks one thread and hands that thread's fetched instruction on to decode. The fetch stage fills a single-entry instruction slot per thread. Later stages supply a per-thread stall mask, a per-thread flush mask and a load-miss report. The divider, the shared floating-point unit, the load path and branch resolution return completion pulses, each tagged with a thread id.

Selection is round-robin among the eligible threads and starts with the thread after the one granted last. A thread that issues a divide, a floating-point operation or a branch is parked. A thread that the memory stage reports as missing is parked too. A parked thread is skipped until the matching completion pulse arrives. This keeps a floating-point operation that lasts tens of cycles, or an unresolved branch, from blocking the other threads. It also means the core needs no branch predictor and no out-of-order machinery.

The grant, its valid bit and the selected instruction are combinational outputs of the registered slot and wait state, masked by the current stall and flush inputs.

Top module: `thread_select_sched`

## Requirements
- R1: A thread is eligible in a cycle only if its slot holds an instruction, its wait flag is clear, and neither its stall bit nor its flush bit is high in that cycle.
- R2: Among the eligible threads, the grant goes to the first one found when searching upward with wrap-around, starting at the thread after the one granted last.
- R3: The grant is one-hot, and the valid output is high exactly when the grant is non-zero. The instruction output is the granted thread's slot contents, or all zeros when nothing is granted.
- R4: The class of an instruction is its two top bits: 00 = simple, 01 = divide, 10 = floating point, 11 = branch. Issuing any class other than 00 sets the issuing thread's wait flag at the next clock edge. Issuing a simple instruction does not set it.
- R5: A completion pulse from the divider, the floating-point unit, the load path or branch resolution clears the wait flag of the tagged thread. That thread can be granted from the following cycle on.
- R6: A load-miss report (valid plus thread id) sets that thread's wait flag at the next clock edge.
- R7: When a park (a long-latency issue or a load-miss report) and a completion pulse hit the same thread in the same cycle, the park wins and the wait flag stays set.
- R8: A flush bit empties that thread's slot at the next edge and blocks its grant in the same cycle. The thread's wait flag is not changed by the flush.
- R9: A slot accepts a fill only when it is empty or is being granted in the same cycle. Otherwise the fill is ignored and the old instruction is kept. A flush overrides a fill to the same slot.
- R10: Reset empties all slots, clears all wait flags and sets the search start to thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| fill_vld_i | input | NUM_THREADS | Per-thread fill strobe from fetch |
| fill_instr_i | input | NUM_THREADS*INSTR_W | Per-thread fill instruction, thread t in bits [t*INSTR_W +: INSTR_W] |
| stall_i | input | NUM_THREADS | Per-thread stall from later stages |
| flush_i | input | NUM_THREADS | Per-thread flush of the slot |
| miss_vld_i | input | 1 | Load-miss report valid |
| miss_tid_i | input | TID_W | Thread id of the load miss |
| div_done_vld_i | input | 1 | Divider completion pulse |
| div_done_tid_i | input | TID_W | Thread id of the divider completion |
| fpu_done_vld_i | input | 1 | Floating-point completion pulse |
| fpu_done_tid_i | input | TID_W | Thread id of the floating-point completion |
| ld_done_vld_i | input | 1 | Load-return completion pulse |
| ld_done_tid_i | input | TID_W | Thread id of the load return |
| br_done_vld_i | input | 1 | Branch-resolved pulse |
| br_done_tid_i | input | TID_W | Thread id of the resolved branch |
| grant_o | output | NUM_THREADS | One-hot thread grant |
| grant_vld_o | output | 1 | A thread is granted this cycle |
| grant_instr_o | output | INSTR_W | Instruction of the granted thread |
| slot_full_o | output | NUM_THREADS | Per-thread slot occupancy, for fetch |

## Verification
The two functions that can fall in the same cycle on one thread are parking and waking. A long-latency issue or a load-miss report can coincide with a completion pulse tagged to that same thread. The bench provokes this by pulsing the floating-point completion for a thread in the very cycle that thread is granted a floating-point instruction, while refilling its slot with a simple instruction. It judges the outcome at the ports: the thread must stay ungranted in the following cycles even though its slot is full, and it must be granted one cycle after a later completion pulse. A separate case applies a flush to a parked thread and then refills it. This shows that the flush empties the slot but leaves the thread parked until its completion arrives.

// File: rtl/thread_sel_pkg.sv
`timescale 1ns/1ps
package thread_sel_pkg;

  // Instruction class carried in the two most significant instruction bits.
  typedef enum logic [1:0] {
    CLS_SIMPLE = 2'b00,
    CLS_DIV    = 2'b01,
    CLS_FLOAT  = 2'b10,
    CLS_BRANCH = 2'b11
  } instr_cls_e;

  function automatic instr_cls_e cls_of(input logic [1:0] top_bits);
    return instr_cls_e'(top_bits);
  endfunction

  // Any class other than simple parks the issuing thread.
  function automatic logic parks_thread(input logic [1:0] top_bits);
    return cls_of(top_bits) != CLS_SIMPLE;
  endfunction

endpackage

// File: rtl/tid_decode.sv
`timescale 1ns/1ps
// Turns a set of tagged pulses into a per-thread mask.
module tid_decode #(
  parameter int N     = 4,
  parameter int NSRC  = 4,
  parameter int TID_W = 2
) (
  input  logic [NSRC-1:0]            src_vld,
  input  logic [NSRC-1:0][TID_W-1:0] src_tid,
  output logic [N-1:0]               hit_mask
);

  always_comb begin
    hit_mask = '0;
    for (int s = 0; s < NSRC; s++) begin
      for (int t = 0; t < N; t++) begin
        if (src_vld[s] && (int'(src_tid[s]) == t)) begin
          hit_mask[t] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/thread_slot.sv
`timescale 1ns/1ps
// One thread's fetch slot and wait flag.
module thread_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fill_vld,
  input  logic [W-1:0] fill_instr,
  input  logic         flush,
  input  logic         take,
  input  logic         park_miss,
  input  logic         wake,
  output logic         slot_vld,
  output logic [W-1:0] slot_instr,
  output logic         waiting
);
  import thread_sel_pkg::*;

  logic         vld_q, vld_d;
  logic [W-1:0] instr_q, instr_d;
  logic         instr_en;
  logic         wait_q, wait_d;
  logic         park_issue;
  logic         park_any;

  // Slot: flush beats everything; fill lands when empty or when drained now.
  always_comb begin
    instr_en = fill_vld && !flush && (!vld_q || take);
    instr_d  = fill_instr;
    if (flush) begin
      vld_d = 1'b0;
    end else if (instr_en) begin
      vld_d = 1'b1;
    end else if (take) begin
      vld_d = 1'b0;
    end else begin
      vld_d = vld_q;
    end
  end

  // Wait flag: any park beats a wake in the same cycle; flush leaves it alone.
  always_comb begin
    park_issue = take && parks_thread(instr_q[W-1 -: 2]);
    park_any   = park_issue || park_miss;
    if (park_any) begin
      wait_d = 1'b1;
    end else if (wake) begin
      wait_d = 1'b0;
    end else begin
      wait_d = wait_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      wait_q <= wait_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_q <= '0;
    end else if (instr_en) begin
      instr_q <= instr_d;
    end
  end

  assign slot_vld   = vld_q;
  assign slot_instr = instr_q;
  assign waiting    = wait_q;

endmodule

// File: rtl/rr_pick.sv
`timescale 1ns/1ps
// Round-robin pick: first requester at or after the start index, wrapping.
module rr_pick #(
  parameter int N     = 4,
  parameter int TID_W = 2
) (
  input  logic [N-1:0]     req,
  input  logic [TID_W-1:0] start,
  output logic [N-1:0]     gnt,
  output logic [TID_W-1:0] gnt_idx,
  output logic             any
);

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int i = 0; i < N; i++) begin
      int j;
      j = int'(start) + i;
      if (j >= N) begin
        j = j - N;
      end
      if (!any && req[j]) begin
        any     = 1'b1;
        gnt[j]  = 1'b1;
        gnt_idx = TID_W'(j);
      end
    end
  end

endmodule

// File: rtl/thread_select_sched.sv
`timescale 1ns/1ps
module thread_select_sched #(
  parameter int NUM_THREADS = 4,
  parameter int INSTR_W     = 32,
  parameter int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_THREADS-1:0]         fill_vld_i,
  input  logic [NUM_THREADS*INSTR_W-1:0] fill_instr_i,
  input  logic [NUM_THREADS-1:0]         stall_i,
  input  logic [NUM_THREADS-1:0]         flush_i,
  input  logic                           miss_vld_i,
  input  logic [TID_W-1:0]               miss_tid_i,
  input  logic                           div_done_vld_i,
  input  logic [TID_W-1:0]               div_done_tid_i,
  input  logic                           fpu_done_vld_i,
  input  logic [TID_W-1:0]               fpu_done_tid_i,
  input  logic                           ld_done_vld_i,
  input  logic [TID_W-1:0]               ld_done_tid_i,
  input  logic                           br_done_vld_i,
  input  logic [TID_W-1:0]               br_done_tid_i,
  output logic [NUM_THREADS-1:0]         grant_o,
  output logic                           grant_vld_o,
  output logic [INSTR_W-1:0]             grant_instr_o,
  output logic [NUM_THREADS-1:0]         slot_full_o
);

  localparam int N         = NUM_THREADS;
  localparam int W         = INSTR_W;
  localparam int NUM_WAKE  = 4;
  localparam logic [TID_W-1:0] LAST_TID = TID_W'(N - 1);

  logic [N-1:0]          slot_vld;
  logic [N-1:0][W-1:0]   slot_instr;
  logic [N-1:0]          wait_vec;
  logic [N-1:0]          wake_vec;
  logic [N-1:0]          miss_vec;
  logic [N-1:0]          eligible;
  logic [N-1:0]          gnt;
  logic [TID_W-1:0]      gnt_idx;
  logic                  gnt_any;
  logic [TID_W-1:0]      start_q, start_d;
  logic                  start_en;
  logic [W-1:0]          instr_mux;

  logic [NUM_WAKE-1:0]            wake_src_vld;
  logic [NUM_WAKE-1:0][TID_W-1:0] wake_src_tid;

  assign wake_src_vld = {br_done_vld_i, ld_done_vld_i, fpu_done_vld_i, div_done_vld_i};
  assign wake_src_tid = {br_done_tid_i, ld_done_tid_i, fpu_done_tid_i, div_done_tid_i};

  tid_decode #(.N(N), .NSRC(NUM_WAKE), .TID_W(TID_W)) u_wake_dec (
    .src_vld  (wake_src_vld),
    .src_tid  (wake_src_tid),
    .hit_mask (wake_vec)
  );

  tid_decode #(.N(N), .NSRC(1), .TID_W(TID_W)) u_miss_dec (
    .src_vld  (miss_vld_i),
    .src_tid  (miss_tid_i),
    .hit_mask (miss_vec)
  );

  for (genvar t = 0; t < N; t++) begin : g_slot
    thread_slot #(.W(W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_vld   (fill_vld_i[t]),
      .fill_instr (fill_instr_i[t*W +: W]),
      .flush      (flush_i[t]),
      .take       (gnt[t]),
      .park_miss  (miss_vec[t]),
      .wake       (wake_vec[t]),
      .slot_vld   (slot_vld[t]),
      .slot_instr (slot_instr[t]),
      .waiting    (wait_vec[t])
    );
  end

  assign eligible = slot_vld & ~wait_vec & ~stall_i & ~flush_i;

  rr_pick #(.N(N), .TID_W(TID_W)) u_pick (
    .req     (eligible),
    .start   (start_q),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .any     (gnt_any)
  );

  // Search start moves to the thread after the winner.
  always_comb begin
    start_en = gnt_any;
    start_d  = (gnt_idx == LAST_TID) ? '0 : gnt_idx + TID_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
    end else if (start_en) begin
      start_q <= start_d;
    end
  end

  always_comb begin
    instr_mux = '0;
    for (int t = 0; t < N; t++) begin
      instr_mux = instr_mux | (slot_instr[t] & {W{gnt[t]}});
    end
  end

  assign grant_o       = gnt;
  assign grant_vld_o   = gnt_any;
  assign grant_instr_o = instr_mux;
  assign slot_full_o   = slot_vld;

endmodule

// File: rtl/thread_select_sched_chk.sv
`timescale 1ns/1ps
module thread_select_sched_chk #(
  parameter int N = 4,
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] grant_o,
  input logic         grant_vld_o,
  input logic [W-1:0] grant_instr_o,
  input logic [N-1:0] stall_i,
  input logic [N-1:0] flush_i,
  input logic [N-1:0] slot_vld,
  input logic [N-1:0] wait_vec,
  input logic [N-1:0] wake_vec,
  input logic [N-1:0] miss_vec
);

  assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  assert_grant_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld_o == (grant_o != '0));

  assert_grant_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~(slot_vld & ~wait_vec & ~stall_i & ~flush_i)) == '0);

  for (genvar t = 0; t < N; t++) begin : g_thr
    assert_issue_parks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o[t] && (grant_instr_o[W-1 -: 2] != 2'b00)) |=> wait_vec[t]);

    assert_miss_parks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      miss_vec[t] |=> wait_vec[t]);

    assert_wake_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_vec[t] && !miss_vec[t] && !grant_o[t]) |=> !wait_vec[t]);

    assert_park_beats_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_vec[t] && grant_o[t] && (grant_instr_o[W-1 -: 2] != 2'b00)) |=> wait_vec[t]);

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i[t] |=> !slot_vld[t]);

    assert_flush_keeps_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_i[t] && wait_vec[t] && !wake_vec[t]) |=> wait_vec[t]);
  end

endmodule

bind thread_select_sched thread_select_sched_chk #(.N(NUM_THREADS), .W(INSTR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .grant_o       (grant_o),
  .grant_vld_o   (grant_vld_o),
  .grant_instr_o (grant_instr_o),
  .stall_i       (stall_i),
  .flush_i       (flush_i),
  .slot_vld      (slot_vld),
  .wait_vec      (wait_vec),
  .wake_vec      (wake_vec),
  .miss_vec      (miss_vec)
);

// File: tb/thread_select_sched_test.sv
`timescale 1ns/1ps
module thread_select_sched_test;

  localparam int N     = 4;
  localparam int W     = 32;
  localparam int TID_W = 2;
  localparam int CLK_P = 20;

  localparam logic [1:0] C_SIM = 2'b00;
  localparam logic [1:0] C_DIV = 2'b01;
  localparam logic [1:0] C_FPU = 2'b10;
  localparam logic [1:0] C_BR  = 2'b11;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]     fill_vld;
  logic [N*W-1:0]   fill_instr;
  logic [N-1:0]     stall, flush;
  logic             miss_vld, div_vld, fpu_vld, ld_vld, br_vld;
  logic [TID_W-1:0] miss_tid, div_tid, fpu_tid, ld_tid, br_tid;
  logic [N-1:0]     grant;
  logic             grant_vld;
  logic [W-1:0]     grant_instr;
  logic [N-1:0]     slot_full;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  thread_select_sched #(.NUM_THREADS(N), .INSTR_W(W)) uut (
    .clk (clk), .rst_n (rst_n),
    .fill_vld_i (fill_vld), .fill_instr_i (fill_instr),
    .stall_i (stall), .flush_i (flush),
    .miss_vld_i (miss_vld), .miss_tid_i (miss_tid),
    .div_done_vld_i (div_vld), .div_done_tid_i (div_tid),
    .fpu_done_vld_i (fpu_vld), .fpu_done_tid_i (fpu_tid),
    .ld_done_vld_i (ld_vld), .ld_done_tid_i (ld_tid),
    .br_done_vld_i (br_vld), .br_done_tid_i (br_tid),
    .grant_o (grant), .grant_vld_o (grant_vld),
    .grant_instr_o (grant_instr), .slot_full_o (slot_full)
  );

  // Table entries: {fill mask, stall mask, expected grant}; all fills are simple.
  localparam int NVEC = 13;
  localparam logic [11:0] VEC [NVEC] = '{
    {4'b1111, 4'b0000, 4'b0000},
    {4'b0000, 4'b0000, 4'b0001},
    {4'b0001, 4'b0000, 4'b0010},
    {4'b0000, 4'b0100, 4'b1000},
    {4'b0000, 4'b0000, 4'b0001},
    {4'b0000, 4'b0000, 4'b0100},
    {4'b0000, 4'b0000, 4'b0000},
    {4'b1111, 4'b0000, 4'b0000},
    {4'b0000, 4'b0000, 4'b1000},
    {4'b0000, 4'b1111, 4'b0000},
    {4'b0000, 4'b0001, 4'b0010},
    {4'b0000, 4'b0000, 4'b0100},
    {4'b0000, 4'b0000, 4'b0001}
  };

  task automatic clear_in();
    fill_vld = '0; fill_instr = '0; stall = '0; flush = '0;
    miss_vld = 1'b0; div_vld = 1'b0; fpu_vld = 1'b0; ld_vld = 1'b0; br_vld = 1'b0;
    miss_tid = '0; div_tid = '0; fpu_tid = '0; ld_tid = '0; br_tid = '0;
  endtask

  task automatic nxt();
    @(negedge clk);
    clear_in();
  endtask

  task automatic do_reset();
    clear_in();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Instruction: {class, 14 zero bits, tag, thread id}.
  task automatic set_fill(input int t, input logic [1:0] cls, input logic [7:0] tag);
    fill_vld[t] = 1'b1;
    fill_instr[t*W +: W] = {cls, 14'h0, tag, 8'(t)};
  endtask

  task automatic chk(input logic [N-1:0] exp, input int tag, input string req);
    logic ok;
    int tid;
    checks++;
    ok = (grant == exp) && (grant_vld == (exp != '0));
    if (exp == '0) begin
      ok = ok && (grant_instr == '0);
    end else begin
      tid = 0;
      for (int i = 0; i < N; i++) if (exp[i]) tid = i;
      ok = ok && (grant_instr[7:0] == 8'(tid));
      if (tag >= 0) ok = ok && (grant_instr[15:8] == 8'(tag));
    end
    if (!ok) begin
      errors++;
      $display("FAIL %s: grant=%b vld=%b instr=%h, expected grant=%b tag=%0d",
               req, grant, grant_vld, grant_instr, exp, tag);
    end
  endtask

  task automatic chk_full(input logic [N-1:0] exp, input string req);
    checks++;
    if (slot_full !== exp) begin
      errors++;
      $display("FAIL %s: slot_full=%b, expected %b", req, slot_full, exp);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clear_in();
    @(negedge clk);
    do_reset();

    // R2 / R1 / R3: round-robin table with stalls and wrap-around.
    for (int v = 0; v < NVEC; v++) begin
      for (int t = 0; t < N; t++) if (VEC[v][11-(3-t)]) set_fill(t, C_SIM, 8'(v));
      stall = VEC[v][7:4];
      #5 chk(VEC[v][3:0], -1, $sformatf("R2 table vector %0d", v));
      nxt();
    end

    // R10: reset state and start pointer back at thread 0.
    do_reset();
    #5 chk('0, -1, "R10 no grant after reset");
    chk_full('0, "R10 slots empty after reset");
    for (int t = 0; t < N; t++) set_fill(t, C_SIM, 8'h00);
    nxt();
    #5 chk(4'b0001, -1, "R10 search starts at thread 0");
    nxt();

    // R4 / R5: divide parks thread 0 until its completion.
    do_reset();
    set_fill(0, C_DIV, 8'h01); set_fill(1, C_SIM, 8'h00);
    #5 chk('0, -1, "R9 fill not visible in the same cycle");
    nxt();
    set_fill(0, C_SIM, 8'h02);
    #5 chk(4'b0001, 1, "R2 thread 0 first");
    nxt();
    #5 chk(4'b0010, 0, "R4 divide parks thread 0");
    nxt();
    div_vld = 1'b1; div_tid = 2'd0;
    #5 chk('0, -1, "R4 parked thread skipped");
    chk_full(4'b0001, "R9 refill accepted on grant");
    nxt();
    #5 chk(4'b0001, 2, "R5 divide completion wakes thread 0");
    nxt();

    // R7: floating-point issue and completion in the same cycle.
    do_reset();
    set_fill(2, C_FPU, 8'h03);
    #5 chk('0, -1, "R1 empty slots");
    nxt();
    set_fill(2, C_SIM, 8'h04);
    fpu_vld = 1'b1; fpu_tid = 2'd2;
    #5 chk(4'b0100, 3, "R4 floating issue on thread 2");
    nxt();
    #5 chk('0, -1, "R7 park wins over same-cycle completion");
    nxt();
    fpu_vld = 1'b1; fpu_tid = 2'd2;
    #5 chk('0, -1, "R7 still parked");
    nxt();
    #5 chk(4'b0100, 4, "R5 floating completion wakes thread 2");
    nxt();

    // R4 / R5: branch parks until resolved.
    do_reset();
    set_fill(3, C_BR, 8'h05);
    nxt();
    set_fill(3, C_SIM, 8'h06);
    #5 chk(4'b1000, 5, "R4 branch issue on thread 3");
    nxt();
    #5 chk('0, -1, "R4 branch parks thread 3");
    nxt();
    br_vld = 1'b1; br_tid = 2'd3;
    #5 chk('0, -1, "R4 branch still unresolved");
    nxt();
    #5 chk(4'b1000, 6, "R5 branch resolve wakes thread 3");
    nxt();

    // R6: load miss parks, load return wakes.
    do_reset();
    set_fill(1, C_SIM, 8'h07);
    miss_vld = 1'b1; miss_tid = 2'd1;
    nxt();
    ld_vld = 1'b1; ld_tid = 2'd1;
    #5 chk('0, -1, "R6 load miss parks thread 1");
    chk_full(4'b0010, "R6 slot still full while parked");
    nxt();
    #5 chk(4'b0010, 7, "R5 load return wakes thread 1");
    nxt();

    // R8: flush blocks, empties and leaves the wait flag.
    do_reset();
    set_fill(0, C_SIM, 8'h08);
    nxt();
    flush[0] = 1'b1;
    #5 chk('0, -1, "R8 flush blocks same-cycle grant");
    nxt();
    #5 chk('0, -1, "R8 nothing left after flush");
    chk_full('0, "R8 flush empties slot");
    nxt();
    set_fill(1, C_DIV, 8'h05);
    nxt();
    set_fill(1, C_SIM, 8'h06);
    #5 chk(4'b0010, 5, "R4 divide on thread 1");
    nxt();
    flush[1] = 1'b1;
    nxt();
    set_fill(1, C_SIM, 8'h09);
    #5 chk_full('0, "R8 parked slot emptied by flush");
    nxt();
    div_vld = 1'b1; div_tid = 2'd1;
    #5 chk('0, -1, "R8 flush left thread 1 parked");
    nxt();
    #5 chk(4'b0010, 9, "R8 wake after flush grants new instruction");
    nxt();

    // R9 / R1: fill to a full slot is ignored; stall blocks; flush beats fill.
    do_reset();
    set_fill(0, C_SIM, 8'h11);
    nxt();
    stall[0] = 1'b1;
    set_fill(0, C_SIM, 8'h22);
    #5 chk('0, -1, "R1 stalled thread not granted");
    nxt();
    #5 chk(4'b0001, 8'h11, "R9 fill to full slot ignored");
    nxt();
    flush[2] = 1'b1;
    set_fill(2, C_SIM, 8'h33);
    nxt();
    #5 chk_full('0, "R9 flush beats fill");
    chk('0, -1, "R9 no grant after flushed fill");
    nxt();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule